// File: doc/BRIEF.md
# Legacy DMA Channel Register File

This block holds the programmable state of one four-channel DMA controller behind an 8-bit I/O port. Each channel keeps a 16-bit address and a 16-bit count. Both have a base copy and a current copy. Software reaches them one byte at a time through a single byte pointer that all channels share. The block also holds a mode byte per channel, a four-bit mask and a latched terminal-count status.

A per-channel step input stands in for the transfer engine. Each step advances the channel's current address and count, so that terminal count, count wrap and auto-initialize reload can all be exercised. The count register holds the transfer length minus one.

The byte pointer is a two-state machine:
- PTR_LO moves to PTR_HI on any read or write of an address or count port.
- PTR_HI moves back to PTR_LO on the next such access.
- A write to the clear port forces PTR_LO from either state.

Port map:

| Port number | Access | Use |
|---|---|---|
| 0 to 3 | read/write | address of channel n |
| 4 to 7 | read/write | count of channel n |
| 8 | read | status |
| 9 | write | mode |
| 10 | write | single-channel mask |
| 11 | read/write | mask-all, and mask readback |
| 12 | write | clear byte pointer |

Top module: `dmar_regfile`

## Requirements
- R1: After reset, all four mask bits are set, the byte pointer is in PTR_LO, status reads 0, and every address and count register is 0.
- R2: A write to port n (0..3) loads one byte of channel n's base and current address, and a write to port 4+n does the same for its count. The low byte is written when the pointer is in PTR_LO and the high byte when it is in PTR_HI.
- R3: Every read or write of ports 0..7 toggles the byte pointer. A write of any data to port 12 returns it to PTR_LO.
- R4: A read of ports 0..7 returns the selected byte of the channel's current address or current count.
- R5: A write to port 10 selects the channel with bits 1:0. Bit 2 = 1 masks that channel and bit 2 = 0 unmasks it.
- R6: A write to port 11 loads all four mask bits from data bits 3:0. A read of port 11 returns the mask in bits 3:0, with zeros above.
- R7: A write to port 9 stores the whole byte as the mode of the channel in bits 1:0. The fields are:
  - bits 3:2: transfer type (01 write, 10 read);
  - bit 4: auto-initialize;
  - bits 7:6: mode (00 demand, 01 single, 11 cascade).
  
  The four mode bytes appear on `mode_flat`, channel n at bits 8n+7:8n.
- R8: A step on a channel whose count is not zero increments its current address and decrements its current count.
- R9: A step at count 0 without auto-initialize sets the channel's terminal-count flag, wraps the count to 0xFFFF and increments the address.
- R10: A step at count 0 with auto-initialize sets the terminal-count flag and reloads the current address and count from their base values.
- R11: A read of port 8 returns the terminal-count flags of channels 0..3 in bits 3:0 and clears them. A flag set by a step in the same cycle survives the clear.
- R12: A step is ignored if the channel is masked, if the channel is in cascade mode, or if the channel's address or count port is written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Port write strobe |
| io_rd | input | 1 | Port read strobe (ignored while io_wr is high) |
| io_port | input | 4 | Port number |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; combinational, 0 when not reading |
| xfer_step | input | 4 | Per-channel transfer step |
| mode_flat | output | 32 | Mode byte of each channel |

## Verification
A status read, which clears the flags, can fall in the same cycle as a step that takes a channel through terminal count, which sets one. The bench first leaves one flag pending. It then drives a status read together with a step on a different channel whose count is already zero. The judgement has two parts: the read data must show only the old flag, and a second status read must show only the new one. A second collision is also provoked: a count write and a step on the same channel in one cycle. There the written byte must win and the address must stay put.

// File: rtl/dmar_pkg.sv
package dmar_pkg;

    // Byte pointer shared by all 16-bit registers.
    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ptr_state_t;

    // Control port numbers (address ports 0..3, count ports 4..7).
    localparam logic [3:0] PORT_STATUS  = 4'd8;
    localparam logic [3:0] PORT_MODE    = 4'd9;
    localparam logic [3:0] PORT_MASK1   = 4'd10;
    localparam logic [3:0] PORT_MASKALL = 4'd11;
    localparam logic [3:0] PORT_CLRPTR  = 4'd12;

    // Mode byte fields.
    localparam int          MODE_AUTO_BIT  = 4;
    localparam logic [1:0]  MODE_CASCADE   = 2'b11;
    localparam int          MASK_FLAG_BIT  = 2;

endpackage

// File: rtl/dmar_ptr_fsm.sv
module dmar_ptr_fsm
    import dmar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic toggle,
    input  logic clear,
    output logic ptr_hi
);

    ptr_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PTR_LO;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = PTR_LO;
        end else if (toggle) begin
            unique case (state_q)
                PTR_LO: state_d = PTR_HI;
                PTR_HI: state_d = PTR_LO;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ptr_hi = (state_q == PTR_HI);
    end

endmodule

// File: rtl/dmar_chan.sv
module dmar_chan #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_addr,
    input  logic            wr_cnt,
    input  logic            hi_sel,
    input  logic [DW-1:0]   wdata,
    input  logic            step_en,
    input  logic            autoinit,
    output logic [2*DW-1:0] cur_addr,
    output logic [2*DW-1:0] cur_cnt,
    output logic            tc_hit
);

    localparam int RW = 2 * DW;

    logic [RW-1:0] base_addr_q, base_cnt_q;
    logic [RW-1:0] cur_addr_q, cur_cnt_q;
    logic          at_zero;

    assign at_zero = (cur_cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr_q <= '0;
            base_cnt_q  <= '0;
            cur_addr_q  <= '0;
            cur_cnt_q   <= '0;
        end else if (wr_addr) begin
            if (hi_sel) begin
                base_addr_q[RW-1:DW] <= wdata;
                cur_addr_q[RW-1:DW]  <= wdata;
            end else begin
                base_addr_q[DW-1:0]  <= wdata;
                cur_addr_q[DW-1:0]   <= wdata;
            end
        end else if (wr_cnt) begin
            if (hi_sel) begin
                base_cnt_q[RW-1:DW]  <= wdata;
                cur_cnt_q[RW-1:DW]   <= wdata;
            end else begin
                base_cnt_q[DW-1:0]   <= wdata;
                cur_cnt_q[DW-1:0]    <= wdata;
            end
        end else if (step_en) begin
            if (at_zero && autoinit) begin
                cur_addr_q <= base_addr_q;
                cur_cnt_q  <= base_cnt_q;
            end else begin
                cur_addr_q <= cur_addr_q + 1'b1;
                cur_cnt_q  <= cur_cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        cur_addr = cur_addr_q;
        cur_cnt  = cur_cnt_q;
        tc_hit   = step_en && at_zero;
    end

endmodule

// File: rtl/dmar_ctrl.sv
module dmar_ctrl
    import dmar_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic              wr_mask1,
    input  logic              wr_maskall,
    input  logic              rd_status,
    input  logic [DW-1:0]     wdata,
    input  logic [NCH-1:0]    tc_hit,
    output logic [NCH-1:0]    mask,
    output logic [NCH-1:0]    autoinit,
    output logic [NCH-1:0]    cascade,
    output logic [NCH-1:0]    tc_flags,
    output logic [NCH*DW-1:0] mode_flat
);

    localparam int CW = $clog2(NCH);

    logic [NCH-1:0] mask_q, tc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_maskall) begin
            mask_q <= wdata[NCH-1:0];
        end else if (wr_mask1) begin
            mask_q[wdata[CW-1:0]] <= wdata[MASK_FLAG_BIT];
        end
    end

    // Set wins over the read-side clear.
    always_ff @(posedge clk) begin
        if (!rst_n) tc_q <= '0;
        else        tc_q <= (rd_status ? '0 : tc_q) | tc_hit;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_mode
        logic [DW-1:0] mode_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_q <= '0;
            else if (wr_mode && wdata[CW-1:0] == CW'(i))
                mode_q <= wdata;
        end
        always_comb begin
            autoinit[i]              = mode_q[MODE_AUTO_BIT];
            cascade[i]               = (mode_q[DW-1:DW-2] == MODE_CASCADE);
            mode_flat[i*DW +: DW]    = mode_q;
        end
    end

    always_comb begin
        mask     = mask_q;
        tc_flags = tc_q;
    end

endmodule

// File: rtl/dmar_regfile.sv
module dmar_regfile
    import dmar_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int PW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [PW-1:0]     io_port,
    input  logic [DW-1:0]     io_wdata,
    output logic [DW-1:0]     io_rdata,
    input  logic [NCH-1:0]    xfer_step,
    output logic [NCH*DW-1:0] mode_flat
);

    localparam int RW = 2 * DW;

    logic              rd_eff, reg_access, ptr_hi;
    logic              wr_mode, wr_mask1, wr_maskall, wr_clr, rd_status;
    logic [NCH-1:0]    wr_addr, wr_cnt, step_en, tc_hit;
    logic [NCH-1:0]    mask_bits, autoinit, cascade, tc_bits;
    logic [NCH*RW-1:0] addr_flat, cnt_flat;

    // Port decode
    always_comb begin
        rd_eff     = io_rd && !io_wr;
        reg_access = (io_wr || rd_eff) && (io_port < PW'(2 * NCH));
        wr_mode    = io_wr && (io_port == PORT_MODE);
        wr_mask1   = io_wr && (io_port == PORT_MASK1);
        wr_maskall = io_wr && (io_port == PORT_MASKALL);
        wr_clr     = io_wr && (io_port == PORT_CLRPTR);
        rd_status  = rd_eff && (io_port == PORT_STATUS);
    end

    dmar_ptr_fsm u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .toggle (reg_access),
        .clear  (wr_clr),
        .ptr_hi (ptr_hi)
    );

    dmar_ctrl #(.NCH(NCH), .DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_mode    (wr_mode),
        .wr_mask1   (wr_mask1),
        .wr_maskall (wr_maskall),
        .rd_status  (rd_status),
        .wdata      (io_wdata),
        .tc_hit     (tc_hit),
        .mask       (mask_bits),
        .autoinit   (autoinit),
        .cascade    (cascade),
        .tc_flags   (tc_bits),
        .mode_flat  (mode_flat)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_comb begin
            wr_addr[i] = io_wr && (io_port == PW'(i));
            wr_cnt[i]  = io_wr && (io_port == PW'(NCH + i));
            step_en[i] = xfer_step[i] && !mask_bits[i] && !cascade[i]
                         && !wr_addr[i] && !wr_cnt[i];
        end

        dmar_chan #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_addr  (wr_addr[i]),
            .wr_cnt   (wr_cnt[i]),
            .hi_sel   (ptr_hi),
            .wdata    (io_wdata),
            .step_en  (step_en[i]),
            .autoinit (autoinit[i]),
            .cur_addr (addr_flat[i*RW +: RW]),
            .cur_cnt  (cnt_flat[i*RW +: RW]),
            .tc_hit   (tc_hit[i])
        );
    end

    // Read mux
    always_comb begin
        logic [RW-1:0] word;
        word     = '0;
        io_rdata = '0;
        if (rd_eff) begin
            if (io_port < PW'(NCH)) begin
                word     = addr_flat[io_port[$clog2(NCH)-1:0]*RW +: RW];
                io_rdata = ptr_hi ? word[RW-1:DW] : word[DW-1:0];
            end else if (io_port < PW'(2 * NCH)) begin
                word     = cnt_flat[io_port[$clog2(NCH)-1:0]*RW +: RW];
                io_rdata = ptr_hi ? word[RW-1:DW] : word[DW-1:0];
            end else if (io_port == PORT_STATUS) begin
                io_rdata = {{(DW-NCH){1'b0}}, tc_bits};
            end else if (io_port == PORT_MASKALL) begin
                io_rdata = {{(DW-NCH){1'b0}}, mask_bits};
            end
        end
    end

endmodule

// File: rtl/dmar_regfile_chk.sv
module dmar_regfile_chk
    import dmar_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int PW  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic              io_rd,
    input logic [PW-1:0]     io_port,
    input logic [NCH-1:0]    wdata_lo,
    input logic [NCH-1:0]    xfer_step,
    input logic              ptr_hi,
    input logic [NCH-1:0]    mask_bits,
    input logic [NCH-1:0]    tc_bits,
    input logic [NCH-1:0]    tc_hit,
    input logic [NCH-1:0]    step_en,
    input logic [NCH*2*DW-1:0] addr_flat,
    input logic [NCH*2*DW-1:0] cnt_flat
);

    localparam int RW = 2 * DW;
    localparam int CW = $clog2(NCH);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mask_bits == '1 && !ptr_hi && tc_bits == '0));

    assert_clear_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port == PORT_CLRPTR) |=> !ptr_hi);

    assert_toggle_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_wr || io_rd) && io_port < PW'(2 * NCH)) |=> (ptr_hi != $past(ptr_hi)));

    assert_mask_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port == PORT_MASKALL) |=> (mask_bits == $past(wdata_lo)));

    assert_status_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && io_port == PORT_STATUS && tc_hit == '0) |=> (tc_bits == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_a
        assert_mask_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (io_wr && io_port == PORT_MASK1 && wdata_lo[CW-1:0] == CW'(i))
            |=> (mask_bits[i] == $past(wdata_lo[MASK_FLAG_BIT])));

        assert_tc_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
            tc_hit[i] |=> tc_bits[i]);

        assert_count_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (step_en[i] && cnt_flat[i*RW +: RW] != '0)
            |=> (cnt_flat[i*RW +: RW] == $past(cnt_flat[i*RW +: RW]) - 1'b1));

        assert_masked_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_step[i] && mask_bits[i] && !io_wr)
            |=> ($stable(addr_flat[i*RW +: RW]) && $stable(cnt_flat[i*RW +: RW])));
    end

endmodule

bind dmar_regfile dmar_regfile_chk #(.NCH(NCH), .DW(DW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_port   (io_port),
    .wdata_lo  (io_wdata[NCH-1:0]),
    .xfer_step (xfer_step),
    .ptr_hi    (ptr_hi),
    .mask_bits (mask_bits),
    .tc_bits   (tc_bits),
    .tc_hit    (tc_hit),
    .step_en   (step_en),
    .addr_flat (addr_flat),
    .cnt_flat  (cnt_flat)
);

// File: tb/sim_dmar_regfile.sv
`timescale 1ns/1ps
module sim_dmar_regfile;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [3:0] io_port = '0;
    logic [7:0] io_wdata = '0;
    logic [3:0] xfer_step = '0;
    wire  [7:0] io_rdata;
    wire  [31:0] mode_flat;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dmar_regfile u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_port   (io_port),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .xfer_step (xfer_step),
        .mode_flat (mode_flat)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_ba [4];
    logic [15:0] m_ca [4];
    logic [15:0] m_bc [4];
    logic [15:0] m_cc [4];
    logic [7:0]  m_mode [4];
    logic [3:0]  m_mask, m_tc;
    bit          m_ptr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_ba[c] = 0; m_ca[c] = 0; m_bc[c] = 0; m_cc[c] = 0; m_mode[c] = 0;
            end
            m_mask = 4'hF; m_tc = 0; m_ptr = 0;
        end else begin
            int p;
            p = int'(io_port);
            if (io_rd && !io_wr && p == 8) m_tc = 0;
            for (int c = 0; c < 4; c++) begin
                bit blk;
                blk = io_wr && (p == c || p == c + 4);
                if (xfer_step[c] && !m_mask[c] && m_mode[c][7:6] != 2'b11 && !blk) begin
                    if (m_cc[c] == 0) begin
                        m_tc[c] = 1'b1;
                        if (m_mode[c][4]) begin
                            m_ca[c] = m_ba[c]; m_cc[c] = m_bc[c];
                        end else begin
                            m_cc[c] = 16'hFFFF; m_ca[c] = m_ca[c] + 1;
                        end
                    end else begin
                        m_ca[c] = m_ca[c] + 1; m_cc[c] = m_cc[c] - 1;
                    end
                end
            end
            if (io_wr) begin
                if (p < 4) begin
                    if (m_ptr) begin m_ba[p][15:8] = io_wdata; m_ca[p][15:8] = io_wdata; end
                    else       begin m_ba[p][7:0]  = io_wdata; m_ca[p][7:0]  = io_wdata; end
                end else if (p < 8) begin
                    if (m_ptr) begin m_bc[p-4][15:8] = io_wdata; m_cc[p-4][15:8] = io_wdata; end
                    else       begin m_bc[p-4][7:0]  = io_wdata; m_cc[p-4][7:0]  = io_wdata; end
                end else if (p == 9)  m_mode[io_wdata[1:0]] = io_wdata;
                else if (p == 10) m_mask[io_wdata[1:0]] = io_wdata[2];
                else if (p == 11) m_mask = io_wdata[3:0];
                else if (p == 12) m_ptr = 0;
            end
            if ((io_wr || io_rd) && p < 8) m_ptr = !m_ptr;
        end
    end

    function automatic logic [7:0] exp_rdata();
        int p;
        p = int'(io_port);
        if (!io_rd || io_wr) return 8'h00;
        if (p < 4) return m_ptr ? m_ca[p][15:8] : m_ca[p][7:0];
        if (p < 8) return m_ptr ? m_cc[p-4][15:8] : m_cc[p-4][7:0];
        if (p == 8)  return {4'h0, m_tc};
        if (p == 11) return {4'h0, m_mask};
        return 8'h00;
    endfunction

    task automatic check(string req, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // Compare the model against the design on every clock.
    always @(negedge clk) begin
        #3;
        if (rst_n && !finished) begin
            string rq;
            if (io_port < 8)        rq = "R4 read";
            else if (io_port == 8)  rq = "R11 status";
            else                    rq = "R6 mask read";
            check(rq, io_rdata, exp_rdata());
            check("R7 mode bytes", mode_flat,
                  {m_mode[3], m_mode[2], m_mode[1], m_mode[0]});
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input int port, input int data);
        @(negedge clk);
        io_wr = 1'b1; io_port = 4'(port); io_wdata = 8'(data);
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input int port, output int data);
        @(negedge clk);
        io_rd = 1'b1; io_port = 4'(port);
        #2 data = int'(io_rdata);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic rd16(input int port, output int data);
        int lo, hi;
        rd(port, lo);
        rd(port, hi);
        data = (hi << 8) | lo;
    endtask

    task automatic wr16(input int port, input int data);
        wr(port, data & 8'hFF);
        wr(port, (data >> 8) & 8'hFF);
    endtask

    task automatic step(input int chmask);
        @(negedge clk);
        xfer_step = 4'(chmask);
        @(negedge clk);
        xfer_step = 4'h0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(11, v);   check("R1 mask after reset", v, 8'h0F);
        rd(8, v);    check("R1 status after reset", v, 0);
        rd16(0, v);  check("R1 address after reset", v, 0);
        rd16(5, v);  check("R1 count after reset", v, 0);

        // R2 byte-pair writes
        wr16(1, 16'h1234);
        wr16(5, 16'h0002);
        rd16(1, v);  check("R2 address ch1", v, 16'h1234);
        rd16(5, v);  check("R2 count ch1", v, 16'h0002);

        // R3 clear of pointer, and toggle on read
        wr(2, 8'hAA);
        wr(12, 8'h77);
        wr16(2, 16'h6655);
        rd16(2, v);  check("R3 clear pointer", v, 16'h6655);
        rd(1, v);    check("R3 first read low", v, 8'h34);
        rd(1, v);    check("R3 read toggles", v, 8'h12);

        // R5 single mask, R6 mask-all
        wr(10, 8'h01); rd(11, v); check("R5 unmask ch1", v, 8'h0D);
        wr(10, 8'h05); rd(11, v); check("R5 mask ch1", v, 8'h0F);
        wr(11, 8'hFA); rd(11, v); check("R6 mask all", v, 8'h0A);
        wr(11, 8'h00); rd(11, v); check("R6 mask none", v, 8'h00);

        // R7, R8, R9 plain transfer through terminal count
        wr(9, 8'h49);
        step(4'b0010);
        rd16(1, v);  check("R8 address step", v, 16'h1235);
        rd16(5, v);  check("R8 count step", v, 16'h0001);
        step(4'b0010);
        step(4'b0010);
        rd16(5, v);  check("R9 count wrap", v, 16'hFFFF);
        rd16(1, v);  check("R9 address after tc", v, 16'h1237);
        rd(8, v);    check("R9 tc flag", v, 8'h02);
        rd(8, v);    check("R11 read clears", v, 8'h00);

        // R10 auto-initialize
        wr16(6, 16'h0001);
        wr(9, 8'h5A);
        step(4'b0100);
        rd16(2, v);  check("R10 address before tc", v, 16'h6656);
        step(4'b0100);
        rd16(2, v);  check("R10 address reload", v, 16'h6655);
        rd16(6, v);  check("R10 count reload", v, 16'h0001);
        rd(8, v);    check("R10 tc flag", v, 8'h04);

        // R12 ignored steps
        wr(10, 8'h05);
        step(4'b0010);
        rd16(1, v);  check("R12 masked address", v, 16'h1237);
        rd16(5, v);  check("R12 masked count", v, 16'hFFFF);
        wr(9, 8'hC0);
        step(4'b0001);
        rd16(0, v);  check("R12 cascade address", v, 0);
        rd(8, v);    check("R12 cascade no tc", v, 0);
        wr(12, 0);
        @(negedge clk);
        io_wr = 1'b1; io_port = 4'd6; io_wdata = 8'h05; xfer_step = 4'b0100;
        @(negedge clk);
        io_wr = 1'b0; xfer_step = 4'h0;
        wr(12, 0);
        rd16(6, v);  check("R12 write beats step count", v, 16'h0005);
        rd16(2, v);  check("R12 write beats step address", v, 16'h6655);

        // R11 status read and terminal count in the same cycle
        wr16(6, 16'h0000);
        step(4'b0100);
        wr(10, 8'h03);
        wr(9, 8'h43);
        @(negedge clk);
        io_rd = 1'b1; io_port = 4'd8; xfer_step = 4'b1000;
        #2 v = int'(io_rdata);
        check("R11 collision read old flags", v, 8'h04);
        @(negedge clk);
        io_rd = 1'b0; xfer_step = 4'h0;
        rd(8, v);    check("R11 new flag survives clear", v, 8'h08);
        rd16(7, v);  check("R9 ch3 count wrap", v, 16'hFFFF);
        rd16(3, v);  check("R9 ch3 address", v, 16'h0001);

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule